// File: doc/BRIEF.md
# Interrupt Pin Filter and Edge/Level Detector

This block sits between one external interrupt pin and the interrupt logic of a small controller. The raw pin is first brought into the clock domain by a short synchronizer. It then passes through a sampling noise filter whose sample period is chosen by software as every cycle, every 32 cycles or every 128 cycles. A fourth setting bypasses the filter. The filter moves its output to a new level only once two consecutive samples agree on that level. A pulse shorter than one sample period is therefore always rejected. A pulse of two sample periods (2, 64 or 256 cycles) is always accepted.

A detector watches the filtered level. It can report a rising edge, a falling edge, both edges, a high level or a low level. Each detected edge gives a one-cycle event strobe, which a timer can count or use for capture. It also sets a sticky pending flag that stays set until the flag is cleared. In the level modes the pending flag simply tracks the level. Both-edge detection is offered only on the filtered path. Level detection is offered only when the filter is bypassed. An unsupported combination reports nothing.

Top module: `irqPinFront`

## Requirements
- R1: `filtSel` picks the sample period: 2'b00 samples every cycle, 2'b01 every DIV_A (32) cycles, 2'b10 every DIV_B (128) cycles, and 2'b11 bypasses the filter.
- R2: With filtering on, `filtLevel` takes a new value only when two consecutive samples agree on it. A pulse shorter than one sample period (1, 31 or 127 cycles) never reaches `filtLevel`. A pulse of two sample periods (2, 64 or 256 cycles) always does.
- R3: In bypass, a level change on `pinRaw` appears on `filtLevel` after exactly 3 rising clock edges.
- R4: With `filtSel`=2'b00, a held change on `pinRaw` appears on `filtLevel` after exactly 4 rising clock edges.
- R5: `detMode` encoding: 3'b001 rising edge, 3'b010 falling edge, 3'b011 both edges, 3'b100 high level, 3'b101 low level. 3'b000, 3'b110 and 3'b111 detect nothing.
- R6: Both-edge mode detects nothing in bypass. The high-level and low-level modes detect nothing while filtering is on (`filtSel` other than 2'b11).
- R7: For each qualified edge of `filtLevel`, `eventPulse` is high for exactly one cycle, in the cycle after `filtLevel` changes. This happens whatever the state of `pendFlag`.
- R8: In edge modes, `pendFlag` goes high in the same cycle as `eventPulse` and stays high until `clrPend` is sampled high. An edge in the same cycle as a clear wins.
- R9: In a supported level mode, `pendFlag` equals the match of `filtLevel` to the selected level, one cycle late, and `clrPend` has no effect on it.
- R10: During reset, `filtLevel`, `pendFlag` and `eventPulse` are 0, and the sample divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | 1 | Unsynchronized external pin |
| filtSel | input | 2 | Sample period / bypass select |
| detMode | input | 3 | Detection mode |
| clrPend | input | 1 | Clears the edge pending flag |
| filtLevel | output | 1 | Filtered pin level |
| pendFlag | output | 1 | Interrupt request |
| eventPulse | output | 1 | One-cycle strobe per qualified edge |

## Verification
A divider that drifts off its period shows up as the wrong pulse widths being accepted. This is visible at `filtLevel` within one or two sample periods, so within at most 256 cycles. A wrong agreement register or synchronizer depth shows up as a latency that is off by a cycle, or as a glitch being passed, and is seen in the next 3 to 4 cycles. Stale edge history or a wrong pending state shows up on `eventPulse` or `pendFlag` one cycle after the filtered level moves. The bench compares all three outputs against an independent model on every cycle.

// File: rtl/irqPinPkg.sv
package irqPinPkg;

  typedef enum logic [1:0] {
    FILT_EACH = 2'b00,
    FILT_MID  = 2'b01,
    FILT_SLOW = 2'b10,
    FILT_OFF  = 2'b11
  } filtSel_e;

  typedef enum logic [2:0] {
    DET_NONE = 3'b000,
    DET_RISE = 3'b001,
    DET_FALL = 3'b010,
    DET_BOTH = 3'b011,
    DET_HIGH = 3'b100,
    DET_LOW  = 3'b101
  } detMode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic sampleTick;
    logic bypass;
    logic riseEn;
    logic fallEn;
    logic levelHi;
    logic levelLo;
  } ctlStrobe_t;

endpackage

// File: rtl/irqFiltCtl.sv
module irqFiltCtl
  import irqPinPkg::*;
#(
  parameter int DIV_A = 32,
  parameter int DIV_B = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] filtSel,
  input  logic [2:0] detMode,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] lastCount;
  logic             divided;
  logic             tick;
  logic             bypass;

  always_comb begin
    divided   = (filtSel == FILT_MID) || (filtSel == FILT_SLOW);
    lastCount = (filtSel == FILT_MID) ? LAST_A : LAST_B;
    tick      = !divided || (divCnt >= lastCount);
    bypass    = (filtSel == FILT_OFF);
  end

  // R1: free-running sample divider, restarts after every tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divCnt <= '0;
    else if (tick)         divCnt <= '0;
    else                   divCnt <= divCnt + 1'b1;
  end

  // R5 / R6: mode decode with per-path support
  always_comb begin
    strobe.sampleTick = tick;
    strobe.bypass     = bypass;
    strobe.riseEn     = (detMode == DET_RISE) || ((detMode == DET_BOTH) && !bypass);
    strobe.fallEn     = (detMode == DET_FALL) || ((detMode == DET_BOTH) && !bypass);
    strobe.levelHi    = (detMode == DET_HIGH) && bypass;
    strobe.levelLo    = (detMode == DET_LOW)  && bypass;
  end

  // R1: divided ticks are never back to back while the divided setting holds
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divided) |=> (!tick || !divided || (filtSel != $past(filtSel))))
    else $error("tick spacing");

  // R1: divider stays inside the slow period
  p_div_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= LAST_B)
    else $error("divider overflow");

endmodule

// File: rtl/irqFiltPath.sv
module irqFiltPath
  import irqPinPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinRaw,
  input  logic       clrPend,
  input  ctlStrobe_t strobe,
  output logic       filtLevel,
  output logic       pendFlag,
  output logic       eventPulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync;
  logic smpLast;
  logic filtQ;
  logic prevFilt;
  logic pendQ;
  logic evQ;
  logic edgeHit;
  logic levelMode;
  logic pastValid;

  // synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];

  // R2 / R3: agreement filter with bypass
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpLast <= 1'b0;
      filtQ   <= 1'b0;
    end else begin
      if (strobe.sampleTick) smpLast <= pinSync;
      if (strobe.bypass)
        filtQ <= pinSync;
      else if (strobe.sampleTick && (pinSync == smpLast))
        filtQ <= pinSync;
    end
  end

  always_comb begin
    edgeHit   = (strobe.riseEn && filtQ && !prevFilt) ||
                (strobe.fallEn && !filtQ && prevFilt);
    levelMode = strobe.levelHi || strobe.levelLo;
  end

  // R7 / R8 / R9: edge history, event strobe, request flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFilt  <= 1'b0;
      evQ       <= 1'b0;
      pendQ     <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      prevFilt  <= filtQ;
      evQ       <= edgeHit;
      if (levelMode)    pendQ <= strobe.levelHi ? filtQ : !filtQ;
      else if (edgeHit) pendQ <= 1'b1;
      else if (clrPend) pendQ <= 1'b0;
    end
  end

  assign filtLevel  = filtQ;
  assign pendFlag   = pendQ;
  assign eventPulse = evQ;

  // R2: with filtering on, the filtered level only moves on a sample tick
  p_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobe.bypass) && (filtQ != $past(filtQ))) |-> $past(strobe.sampleTick))
    else $error("filter moved off tick");

  // R8: an event outside level mode leaves the request set
  p_event_sets_pend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && evQ && !$past(levelMode)) |-> pendQ)
    else $error("event without request");

  // R8: request is sticky without a clear
  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !clrPend && !levelMode) |=> pendQ)
    else $error("request dropped");

  // R6: level strobes never coexist with edge strobes
  p_mode_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.levelHi, strobe.levelLo, strobe.riseEn | strobe.fallEn}))
    else $error("mode overlap");

endmodule

// File: rtl/irqPinFront.sv
module irqPinFront
  import irqPinPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 32,
  parameter int DIV_B       = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinRaw,
  input  logic [1:0] filtSel,
  input  logic [2:0] detMode,
  input  logic       clrPend,
  output logic       filtLevel,
  output logic       pendFlag,
  output logic       eventPulse
);
  ctlStrobe_t strobe;

  irqFiltCtl #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .filtSel (filtSel),
    .detMode (detMode),
    .strobe  (strobe)
  );

  irqFiltPath #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .pinRaw     (pinRaw),
    .clrPend    (clrPend),
    .strobe     (strobe),
    .filtLevel  (filtLevel),
    .pendFlag   (pendFlag),
    .eventPulse (eventPulse)
  );

  // R10: nothing is reported straight out of reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rstN) |-> (!pendFlag && !eventPulse && !filtLevel))
    else $error("outputs active at reset exit");

endmodule

// File: tb/irqPinFront_bench.sv
`timescale 1ns/1ps
module irqPinFront_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRaw = 1'b0;
  logic [1:0] filtSel = 2'b00;
  logic [2:0] detMode = 3'b000;
  logic clrPend = 1'b0;
  logic filtLevel, pendFlag, eventPulse;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqPinFront u_irqPinFront (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .filtSel(filtSel),
    .detMode(detMode), .clrPend(clrPend), .filtLevel(filtLevel),
    .pendFlag(pendFlag), .eventPulse(eventPulse)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // ---------- reference model built from the requirements ----------
  logic mS1, mS2, mSmp, mFilt, mPrev, mPend, mEv;
  int   mCnt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mSmp <= 0; mFilt <= 0; mPrev <= 0;
      mPend <= 0; mEv <= 0; mCnt <= 0;
    end else begin : mdl
      bit divided, tk, rEn, fEn, lHi, lLo, hit;
      int per;
      divided = (filtSel == 2'b01) || (filtSel == 2'b10);
      per = (filtSel == 2'b01) ? 32 : 128;
      tk = !divided || (mCnt >= per - 1);
      mCnt <= tk ? 0 : mCnt + 1;
      mS1 <= pinRaw;
      mS2 <= mS1;
      if (tk) mSmp <= mS2;
      if (filtSel == 2'b11) mFilt <= mS2;
      else if (tk && (mS2 == mSmp)) mFilt <= mS2;
      mPrev <= mFilt;
      rEn = (detMode == 3'd1) || (detMode == 3'd3 && filtSel != 2'b11);
      fEn = (detMode == 3'd2) || (detMode == 3'd3 && filtSel != 2'b11);
      lHi = (detMode == 3'd4) && (filtSel == 2'b11);
      lLo = (detMode == 3'd5) && (filtSel == 2'b11);
      hit = (rEn && mFilt && !mPrev) || (fEn && !mFilt && mPrev);
      mEv <= hit;
      if (lHi) mPend <= mFilt;
      else if (lLo) mPend <= !mFilt;
      else if (hit) mPend <= 1;
      else if (clrPend) mPend <= 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(filtLevel, mFilt, "R2 filtLevel");
      check(eventPulse, mEv, "R7 eventPulse");
      check(pendFlag, mPend, "R8 pendFlag");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearPend();
    @(negedge clk); clrPend = 1;
    @(negedge clk); clrPend = 0;
  endtask

  // latency from a pin change until filtLevel shows it
  task automatic latency(input logic lvl, output int n);
    n = -1;
    @(negedge clk); pinRaw = lvl;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (n < 0 && filtLevel == lvl) n = i;
    end
  endtask

  task automatic pulseSeen(input logic [1:0] sel, input int w, output bit seen);
    seen = 0;
    @(negedge clk); filtSel = sel; detMode = 0; pinRaw = 0;
    waitCyc(300);
    pinRaw = 1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (filtLevel) seen = 1;
    end
    pinRaw = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (filtLevel) seen = 1;
    end
  endtask

  task automatic countEvents(input logic [1:0] sel, input logic [2:0] mode,
                             input int toggles, output int cnt);
    cnt = 0;
    @(negedge clk); filtSel = sel; detMode = mode;
    for (int t = 0; t < toggles; t++) begin
      pinRaw = ~pinRaw;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (eventPulse) cnt++;
      end
    end
  endtask

  initial begin
    int n;
    bit seen;
    int cnt;
    void'($urandom(32'h5EED_1234));
    // R10 reset
    waitCyc(3);
    check(filtLevel, 0, "R10 filtLevel in reset");
    check(pendFlag, 0, "R10 pendFlag in reset");
    check(eventPulse, 0, "R10 eventPulse in reset");
    rstN = 1;
    waitCyc(5);

    // R4 latency and R7/R8 rising event
    filtSel = 2'b00; detMode = 3'd1;
    waitCyc(2);
    @(negedge clk); pinRaw = 1;
    n = -1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (n < 0 && filtLevel) n = i;
      if (i == 5) begin check(eventPulse, 1, "R7 event after rise"); check(pendFlag, 1, "R8 set with event"); end
      if (i == 6) check(eventPulse, 0, "R7 single cycle");
      if (i == 8) check(pendFlag, 1, "R8 held");
    end
    checks++;
    if (n != 4) begin fails++; $display("FAIL R4 latency actual=%0d expected=4", n); end
    clearPend();
    @(negedge clk); check(pendFlag, 0, "R8 cleared");

    // R8 edge wins over same-cycle clear
    pinRaw = 0; waitCyc(10);
    @(negedge clk); pinRaw = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 4) clrPend = 1;
      if (i == 5) begin clrPend = 0; check(pendFlag, 1, "R8 edge beats clear"); end
    end
    clearPend();

    // R3 bypass latency, R9 level mode
    @(negedge clk); pinRaw = 0; filtSel = 2'b11; detMode = 3'd4;
    waitCyc(10);
    latency(1, n);
    checks++;
    if (n != 3) begin fails++; $display("FAIL R3 latency actual=%0d expected=3", n); end
    check(pendFlag, 1, "R9 high level request");
    @(negedge clk); clrPend = 1;
    waitCyc(3);
    check(pendFlag, 1, "R9 clear ignored");
    clrPend = 0;
    pinRaw = 0; waitCyc(6);
    check(pendFlag, 0, "R9 follows level");
    detMode = 3'd5; waitCyc(2);
    check(pendFlag, 1, "R9 low level request");
    detMode = 3'd0; clearPend();

    // R6 unsupported combinations
    countEvents(2'b11, 3'd3, 10, cnt);
    checks++;
    if (cnt != 0) begin fails++; $display("FAIL R6 both-edge in bypass actual=%0d expected=0", cnt); end
    check(pendFlag, 0, "R6 no request both-edge bypass");
    @(negedge clk); filtSel = 2'b00; detMode = 3'd4; pinRaw = 1; waitCyc(10);
    check(pendFlag, 0, "R6 high level while filtered");
    @(negedge clk); detMode = 3'd5; pinRaw = 0; waitCyc(10);
    check(pendFlag, 0, "R6 low level while filtered");

    // R5 mode encodings
    countEvents(2'b00, 3'd0, 8, cnt);
    checks++; if (cnt != 0) begin fails++; $display("FAIL R5 none mode actual=%0d expected=0", cnt); end
    countEvents(2'b00, 3'd6, 8, cnt);
    checks++; if (cnt != 0) begin fails++; $display("FAIL R5 mode 6 actual=%0d expected=0", cnt); end
    countEvents(2'b00, 3'd2, 8, cnt);
    checks++; if (cnt != 4) begin fails++; $display("FAIL R5 falling actual=%0d expected=4", cnt); end
    countEvents(2'b00, 3'd3, 8, cnt);
    checks++; if (cnt != 8) begin fails++; $display("FAIL R5 both actual=%0d expected=8", cnt); end
    detMode = 0; clearPend();

    // R1 / R2 pulse width limits
    pulseSeen(2'b00, 1, seen);   check(seen, 0, "R2 1-cycle pulse rejected");
    pulseSeen(2'b00, 2, seen);   check(seen, 1, "R2 2-cycle pulse accepted");
    pulseSeen(2'b01, 31, seen);  check(seen, 0, "R1 31-cycle pulse rejected");
    pulseSeen(2'b01, 64, seen);  check(seen, 1, "R1 64-cycle pulse accepted");
    pulseSeen(2'b10, 127, seen); check(seen, 0, "R1 127-cycle pulse rejected");
    pulseSeen(2'b10, 256, seen); check(seen, 1, "R1 256-cycle pulse accepted");

    // constrained random, checked per cycle by the model
    for (int seg = 0; seg < 40; seg++) begin
      int maxRun;
      @(negedge clk);
      filtSel = 2'($urandom_range(0, 3));
      detMode = 3'($urandom_range(0, 7));
      maxRun = (filtSel == 2'b01) ? 80 : (filtSel == 2'b10) ? 300 : 6;
      for (int c = 0; c < 500; ) begin
        int run;
        run = $urandom_range(1, maxRun);
        pinRaw = 1'($urandom_range(0, 1));
        for (int k = 0; k < run && c < 500; k++, c++) begin
          clrPend = ($urandom_range(0, 7) == 0);
          @(negedge clk);
        end
      end
      clrPend = 0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule